// File: doc/BRIEF.md
# MIDI Running-Status Expander

This block sits behind a serial byte receiver on a MIDI input. Each received byte comes in on an 8-bit bus with a one-clock strobe. The block turns the byte stream into whole channel messages of three bytes each. Each message leaves as one 24-bit word with its own one-clock strobe. A message queue or a merge stage can use the word directly.

When the sender uses running status, it omits the status byte of repeated messages and sends only the key and velocity. The expander keeps the most recent channel status and puts it back in front of each such pair. Every output word is therefore a full status, key and velocity triple.

Real-time bytes can be interleaved anywhere in the stream and are discarded without disturbing assembly. System-exclusive and system-common bytes are discarded and cancel the remembered status. A parameter sets how wide the class of accepted channel statuses is.

Top module: `midx_expander`

## Requirements
- R1: A byte with bit 7 set is a status byte and a byte with bit 7 clear is a data byte. A completed message appears as `msg_word` = {status[23:16], key[15:8], velocity[7:0]}. `msg_vld` is high for exactly one clock, in the cycle after the clock edge that captured the velocity byte.
- R2: A note-on status 9n (n = channel) followed by two data bytes produces the word {9n, key, velocity}.
- R3: A note-off status 8n followed by two data bytes produces the word {8n, key, velocity}.
- R4: A note-on with velocity 00 is passed on as an ordinary message {9n, key, 00}.
- R5: After an accepted status, each further pair of data bytes with no status between them produces a word that carries the remembered status.
- R6: A new accepted status discards a partly assembled message (a lone key byte) and replaces the remembered status.
- R7: Data bytes received before any accepted status since reset produce no output.
- R8: Real-time bytes F8 to FF are discarded. They do not change the remembered status or the assembly position, even between a key and its velocity.
- R9: System bytes F0 to F7 cancel the remembered status. Data bytes that follow produce no output until a new accepted status arrives.
- R10: With `NOTE_ONLY` = 1, only 8n and 9n are accepted and A0 to EF act like R9. With `NOTE_ONLY` = 0, 8n, 9n, An, Bn and En are accepted and Cn and Dn act like R9.
- R11: After reset, `msg_vld` is 0 and `msg_word` is 0.
- R12: Clocks without `rx_vld` have no effect, and bytes may also arrive on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_vld | input | 1 | One-clock strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| msg_vld | output | 1 | One-clock strobe marking a completed message |
| msg_word | output | 24 | Message word: status, key, velocity |

## Verification
The bench builds two copies of the block side by side on the same input stream. One copy uses `NOTE_ONLY` = 1 and the other uses `NOTE_ONLY` = 0, so each status-acceptance variant is checked against its own arithmetic rule. With the byte width fixed at 8, every one of the 128 status values can be swept under both variants. Each status is preceded by a cancelling system byte and followed by a data pair. Every key value from 0 to 127 is also swept under running status, with a velocity computed from the key, which includes velocity zero.

// File: rtl/midx_pkg.sv
package midx_pkg;
   // classification of one received byte
   typedef enum logic [1:0] {
      BC_DATA = 2'd0,   // top bit clear
      BC_KEEP = 2'd1,   // accepted channel status
      BC_DROP = 2'd2,   // status that cancels the remembered one
      BC_RT   = 2'd3    // real-time, transparent
   } byte_class_e;

   // which data byte is expected next
   typedef enum logic {
      PH_KEY = 1'b0,
      PH_VEL = 1'b1
   } phase_e;
endpackage

// File: rtl/midx_classify.sv
module midx_classify
   import midx_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit NOTE_ONLY = 1'b1
) (
   input  logic [BYTE_W-1:0] in_byte,
   output byte_class_e       cls
);
   localparam int NIB_W = 4;
   localparam int RT_W  = 5;

   if (BYTE_W != 8) begin : g_bad_width
      $error("midx_classify: BYTE_W must be 8");
   end

   logic [NIB_W-1:0] hi_nib;
   logic             accept;
   logic             is_rt;

   assign hi_nib = in_byte[BYTE_W-1 -: NIB_W];
   assign is_rt  = (in_byte[BYTE_W-1 -: RT_W] == {RT_W{1'b1}});

   if (NOTE_ONLY) begin : g_note_only
      assign accept = (hi_nib == 4'h8) || (hi_nib == 4'h9);
   end else begin : g_two_data
      assign accept = (hi_nib == 4'h8) || (hi_nib == 4'h9) ||
                      (hi_nib == 4'hA) || (hi_nib == 4'hB) ||
                      (hi_nib == 4'hE);
   end

   always_comb begin
      if (!in_byte[BYTE_W-1])
         cls = BC_DATA;
      else if (is_rt)
         cls = BC_RT;
      else if (accept)
         cls = BC_KEEP;
      else
         cls = BC_DROP;
   end
endmodule

// File: rtl/midx_assemble.sv
module midx_assemble
   import midx_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_vld,
   input  logic [BYTE_W-1:0]   in_byte,
   input  byte_class_e         cls,
   output logic                emit,
   output logic [3*BYTE_W-1:0] emit_word
);
   logic [BYTE_W-1:0] run_status;
   logic              run_ok;
   phase_e            phase;
   logic [BYTE_W-1:0] key_hold;

   assign emit      = in_vld && (cls == BC_DATA) && run_ok && (phase == PH_VEL);
   assign emit_word = {run_status, key_hold, in_byte};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_status <= '0;
         run_ok     <= 1'b0;
         phase      <= PH_KEY;
         key_hold   <= '0;
      end else if (in_vld) begin
         unique case (cls)
            BC_KEEP: begin
               run_status <= in_byte;
               run_ok     <= 1'b1;
               phase      <= PH_KEY;
            end
            BC_DROP: begin
               run_ok <= 1'b0;
               phase  <= PH_KEY;
            end
            BC_DATA: begin
               if (run_ok) begin
                  if (phase == PH_KEY) begin
                     key_hold <= in_byte;
                     phase    <= PH_VEL;
                  end else begin
                     phase <= PH_KEY;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   AST_RT_TRANSPARENT : assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && cls == BC_RT) |=> ($stable(run_status) && $stable(run_ok) && $stable(phase) && $stable(key_hold))); // R8
   AST_SYS_CANCELS : assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && cls == BC_DROP) |=> (!run_ok && !emit)); // R9
   AST_IDLE_HOLDS : assert property (@(posedge clk) disable iff (!rst_n)
      (!in_vld) |=> ($stable(run_status) && $stable(phase) && $stable(key_hold) && $stable(run_ok))); // R12
   AST_NEW_STATUS_RESTARTS : assert property (@(posedge clk) disable iff (!rst_n)
      (in_vld && cls == BC_KEEP) |=> (phase == PH_KEY && run_ok)); // R6
endmodule

// File: rtl/midx_outreg.sv
module midx_outreg #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_vld,
   input  logic [WORD_W-1:0] d_word,
   output logic              q_vld,
   output logic [WORD_W-1:0] q_word
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_vld  <= 1'b0;
         q_word <= '0;
      end else begin
         q_vld <= d_vld;
         if (d_vld)
            q_word <= d_word;
      end
   end
endmodule

// File: rtl/midx_expander.sv
module midx_expander
   import midx_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter bit NOTE_ONLY = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                rx_vld,
   input  logic [7:0]          rx_byte,
   output logic                msg_vld,
   output logic [23:0]         msg_word
);
   localparam int WORD_W = 3 * BYTE_W;

   if (BYTE_W != 8) begin : g_bad_width
      $error("midx_expander: BYTE_W must be 8");
   end

   byte_class_e       cls;
   logic              emit;
   logic [WORD_W-1:0] emit_word;

   midx_classify #(.BYTE_W(BYTE_W), .NOTE_ONLY(NOTE_ONLY)) u_cls (
      .in_byte (rx_byte),
      .cls     (cls)
   );

   midx_assemble #(.BYTE_W(BYTE_W)) u_asm (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_vld    (rx_vld),
      .in_byte   (rx_byte),
      .cls       (cls),
      .emit      (emit),
      .emit_word (emit_word)
   );

   midx_outreg #(.WORD_W(WORD_W)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_vld  (emit),
      .d_word (emit_word),
      .q_vld  (msg_vld),
      .q_word (msg_word)
   );

   AST_ONE_CLOCK_GUARD : assert property (@(posedge clk) disable iff (!rst_n)
      msg_vld |=> !msg_vld); // R1
   AST_STATUS_TOP : assert property (@(posedge clk) disable iff (!rst_n)
      msg_vld |-> msg_word[WORD_W-1]); // R1
   AST_DATA_TOP : assert property (@(posedge clk) disable iff (!rst_n)
      msg_vld |-> (!msg_word[2*BYTE_W-1] && !msg_word[BYTE_W-1])); // R1
   AST_FROM_INPUT : assert property (@(posedge clk) disable iff (!rst_n)
      msg_vld |-> $past(rx_vld)); // R12
   AST_WORD_HELD : assert property (@(posedge clk) disable iff (!rst_n)
      (!msg_vld && !$past(emit)) |-> $stable(msg_word)); // R1
endmodule

// File: tb/midx_expander_test.sv
`timescale 1ns/1ps
module midx_expander_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_vld = 1'b0;
   logic [7:0]  rx_byte = 8'h00;
   logic        vld_n, vld_w;
   logic [23:0] word_n, word_w;

   int checks = 0;
   int errors = 0;
   int cnt_n = 0;
   int cnt_w = 0;
   logic [23:0] last_n = '0;
   logic [23:0] last_w = '0;

   always #2.5 clk = ~clk;

   midx_expander #(.NOTE_ONLY(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
      .msg_vld(vld_n), .msg_word(word_n));

   midx_expander #(.NOTE_ONLY(1'b0)) uut_wide (
      .clk(clk), .rst_n(rst_n), .rx_vld(rx_vld), .rx_byte(rx_byte),
      .msg_vld(vld_w), .msg_word(word_w));

   always @(negedge clk) begin
      if (vld_n) begin cnt_n <= cnt_n + 1; last_n <= word_n; end
      if (vld_w) begin cnt_w <= cnt_w + 1; last_w <= word_w; end
   end

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk);
      rx_vld  = 1'b1;
      rx_byte = b;
      @(negedge clk);
      rx_vld  = 1'b0;
      #1;
   endtask

   // expects one message on both copies (or none when exp_one == 0)
   task automatic expect_msg(input string tag, input int n0, input int w0,
                             input bit one_n, input bit one_w, input logic [23:0] exp);
      check({tag, " count narrow"}, cnt_n - n0, one_n ? 1 : 0);
      check({tag, " count wide"},   cnt_w - w0, one_w ? 1 : 0);
      if (one_n) check({tag, " word narrow"}, last_n, exp);
      if (one_w) check({tag, " word wide"},   last_w, exp);
   endtask

   function automatic bit acc_narrow(input logic [7:0] s);
      return (s[7:4] == 4'h8) || (s[7:4] == 4'h9);
   endfunction
   function automatic bit acc_wide(input logic [7:0] s);
      return (s[7:4] == 4'h8) || (s[7:4] == 4'h9) || (s[7:4] == 4'hA) ||
             (s[7:4] == 4'hB) || (s[7:4] == 4'hE);
   endfunction

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n0, w0;
      repeat (3) @(negedge clk);
      #1;
      check("R11 reset vld narrow", vld_n, 0);
      check("R11 reset vld wide", vld_w, 0);
      check("R11 reset word narrow", word_n, 0);
      check("R11 reset word wide", word_w, 0);
      @(negedge clk); rst_n = 1'b1;

      // R7: data before any status
      n0 = cnt_n; w0 = cnt_w;
      put(8'h11); put(8'h22); put(8'h33); put(8'h44);
      expect_msg("R7 cold data", n0, w0, 0, 0, '0);

      // R2 note on
      n0 = cnt_n; w0 = cnt_w;
      put(8'h93); put(8'h40); put(8'h7F);
      expect_msg("R2 note on", n0, w0, 1, 1, 24'h93407F);

      // R5 running status
      n0 = cnt_n; w0 = cnt_w;
      put(8'h41); put(8'h22);
      expect_msg("R5 running", n0, w0, 1, 1, 24'h934122);

      // R4 velocity zero
      n0 = cnt_n; w0 = cnt_w;
      put(8'h42); put(8'h00);
      expect_msg("R4 vel zero", n0, w0, 1, 1, 24'h934200);

      // R3 note off plus running
      n0 = cnt_n; w0 = cnt_w;
      put(8'h85); put(8'h10); put(8'h20);
      expect_msg("R3 note off", n0, w0, 1, 1, 24'h851020);
      n0 = cnt_n; w0 = cnt_w;
      put(8'h11); put(8'h00);
      expect_msg("R3 running off", n0, w0, 1, 1, 24'h851100);

      // R6 new status discards lone key
      n0 = cnt_n; w0 = cnt_w;
      put(8'h85); put(8'h10); put(8'h96); put(8'h30); put(8'h31);
      expect_msg("R6 restart", n0, w0, 1, 1, 24'h963031);

      // R8 real-time between key and velocity, and between status and key
      n0 = cnt_n; w0 = cnt_w;
      put(8'h50); put(8'hF8); put(8'h51);
      expect_msg("R8 rt mid", n0, w0, 1, 1, 24'h965051);
      n0 = cnt_n; w0 = cnt_w;
      put(8'h80); put(8'hFE); put(8'h01); put(8'hFA); put(8'h02);
      expect_msg("R8 rt around", n0, w0, 1, 1, 24'h800102);

      // R9 system byte cancels
      n0 = cnt_n; w0 = cnt_w;
      put(8'hF0); put(8'h01); put(8'h02); put(8'h03); put(8'h04);
      expect_msg("R9 cancel", n0, w0, 0, 0, '0);

      // R12 and R1 timing: back-to-back bytes, pulse one cycle after velocity edge
      @(negedge clk); rx_vld = 1'b1; rx_byte = 8'h91;
      @(negedge clk); rx_byte = 8'h05;
      @(negedge clk); rx_byte = 8'h06;
      @(negedge clk); rx_byte = 8'h07;
      #1;
      check("R1 pulse on narrow", vld_n, 1);
      check("R1 pulse on wide", vld_w, 1);
      check("R12 burst word", word_n, 24'h910506);
      @(negedge clk); rx_byte = 8'h08;
      #1;
      check("R1 pulse off narrow", vld_n, 0);
      @(negedge clk); rx_vld = 1'b0;
      #1;
      check("R12 burst second", word_w, 24'h910708);
      check("R1 second pulse", vld_n, 1);
      @(negedge clk); #1;
      check("R1 second pulse off", vld_w, 0);

      // R10 sweep of every status value
      for (int s = 128; s < 256; s++) begin
         logic [7:0] sb;
         sb = s[7:0];
         put(8'hF0);
         n0 = cnt_n; w0 = cnt_w;
         put(sb); put(8'h12); put(8'h34);
         if (sb >= 8'hF8)
            expect_msg("R8 sweep rt", n0, w0, 0, 0, '0);
         else if (sb >= 8'hF0)
            expect_msg("R9 sweep sys", n0, w0, 0, 0, '0);
         else
            expect_msg("R10 sweep status", n0, w0, acc_narrow(sb), acc_wide(sb),
                       {sb, 8'h12, 8'h34});
      end

      // R5 key sweep under running status
      put(8'h9A);
      for (int k = 0; k < 128; k++) begin
         logic [7:0] v;
         v = 8'((k * 5) % 128);
         n0 = cnt_n; w0 = cnt_w;
         put(8'(k)); put(v);
         expect_msg("R5 key sweep", n0, w0, 1, 1, {8'h9A, 8'(k), v});
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule